// File: doc/BRIEF.md
# Edge Timestamp Capture Channel with Low-Power Wake

This block is one input capture channel. An asynchronous pin is brought into the clock domain and reduced to rising and falling edge pulses. The channel then selects edges according to a 3-bit mode and, for two of the modes, divides rising edges by 4 or by 16. For each selected event it copies the value of an external free-running timer into a 4-entry queue. Software drains the queue through a valid/ready read port.

A programmable count of 1 to 4 captures raises a sticky interrupt flag. A separate enable gates whether that flag is presented as an interrupt request, or as a wake request while the CPU is idle or asleep. Mode 111 turns the pin into a plain rising-edge interrupt source that stores no timestamp. This mode keeps working in sleep.

The power mode restricts the channel. In sleep only mode 111 does anything. In idle the capture modes work only while the timer is running and the stop-in-idle control is clear.

Top module: `icap_wake_top`

## Requirements
- R1: After reset, irq_flag_o, irq_req_o, wake_o, rd_valid_o and ovf_o are all 0.
- R2: The pin passes through two synchroniser flops and one edge flop. A level change sampled at clock edge k is treated as an edge at edge k+2, and the timer value present at edge k+2 is stored. Mode 001 stores on both edges, 010 on falling edges and 011 on rising edges.
- R3: Mode 100 stores on every 4th rising edge and mode 101 on every 16th rising edge. The prescale count restarts whenever mode_i changes.
- R4: evt_sel_i values 00, 01, 10 and 11 set the flag on the 1st, 2nd, 3rd and 4th capture. The capture counter restarts when the flag is set by it or when mode_i changes.
- R5: In mode 111 every rising edge sets the flag in any power mode, whatever tmr_en_i is. Nothing is written to the queue.
- R6: With pwr_i = 10 or 11 (sleep), all modes other than 111 store nothing and never set the flag.
- R7: With pwr_i = 01 (idle), the capture modes work only when tmr_en_i = 1 and stop_idle_i = 0. Otherwise edges are ignored. With pwr_i = 00 (run), they always work.
- R8: The flag stays set until a flag_clr_i strobe. If a flag-setting event and flag_clr_i fall in the same cycle, the flag is set.
- R9: irq_req_o = irq_flag_o AND irq_en_i. wake_o is irq_req_o when pwr_i is not 00, and 0 otherwise.
- R10: The read port presents the oldest entry. rd_valid_o and rd_data_o hold while rd_ready_i is low. An entry leaves on a cycle with both high.
- R11: A capture that arrives while the queue holds 4 entries is dropped and sets ovf_o, even if a read takes place in the same cycle. ovf_o stays set until the channel is turned off.
- R12: In modes 000 and 110 the queue is emptied, ovf_o is cleared and no event is produced.
- Even a change of a mode from a given a mode to another (by a mode_i change) takes no event on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture pin |
| tmr_cnt_i | input | TW | Free-running timer value |
| tmr_en_i | input | 1 | Timer running |
| mode_i | input | 3 | Edge/prescale mode |
| evt_sel_i | input | 2 | Captures per interrupt, minus one |
| stop_idle_i | input | 1 | Halt capture modes in idle |
| pwr_i | input | 2 | 00 run, 01 idle, 1x sleep |
| irq_en_i | input | 1 | Interrupt/wake enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| rd_valid_o | output | 1 | Queue head valid |
| rd_ready_i | input | 1 | Reader accepts head |
| rd_data_o | output | TW | Queue head timestamp |
| ovf_o | output | 1 | Queue overflow, sticky |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_req_o | output | 1 | Enabled interrupt request |
| wake_o | output | 1 | Wake request in idle/sleep |

## Verification
Two pairs of functions can meet in the same cycle. The first is a capture that sets the flag against a software clear. The second is a capture that arrives at a full queue against a read handshake that frees a slot. The bench holds flag_clr_i and rd_ready_i high across edge pulses, and also randomises them, so that both pairs collide. A behavioural model expects the flag to win over the clear, and the capture to be dropped with ovf_o raised. It compares every output on every clock.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    MD_OFF    = 3'b000,
    MD_BOTH   = 3'b001,
    MD_FALL   = 3'b010,
    MD_RISE   = 3'b011,
    MD_RISE_A = 3'b100,
    MD_RISE_B = 3'b101,
    MD_RSVD   = 3'b110,
    MD_IRQ    = 3'b111
  } icap_mode_e;

  typedef enum logic [1:0] {
    PW_RUN   = 2'b00,
    PW_IDLE  = 2'b01,
    PW_SLEEP = 2'b10,
    PW_DEEP  = 2'b11
  } icap_pwr_e;

  function automatic logic mode_is_off(input logic [2:0] m);
    return (m == MD_OFF) || (m == MD_RSVD);
  endfunction
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/icap_event_gen.sv
module icap_event_gen
  import icap_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic [2:0] mode_i,
  input  logic [1:0] pwr_i,
  input  logic       tmr_en_i,
  input  logic       stop_idle_i,
  output logic       cap_o,
  output logic       pin_irq_o,
  output logic       chg_o,
  output logic       off_o
);
  localparam int PW = $clog2(DIV_B) + 1;
  localparam logic [PW-1:0] LIM_A = PW'(DIV_A - 1);
  localparam logic [PW-1:0] LIM_B = PW'(DIV_B - 1);

  logic [2:0]    prev_mode;
  logic [PW-1:0] pre_cnt;
  logic          full_fn;
  logic          div_mode;
  logic [PW-1:0] lim;
  logic          div_hit;

  assign chg_o = (mode_i != prev_mode);
  assign off_o = mode_is_off(mode_i);

  // R6/R7: capture modes depend on power state, timer and stop-in-idle
  always_comb begin
    unique case (icap_pwr_e'(pwr_i))
      PW_RUN:  full_fn = 1'b1;
      PW_IDLE: full_fn = tmr_en_i & ~stop_idle_i;
      default: full_fn = 1'b0;
    endcase
  end

  assign div_mode = (mode_i == MD_RISE_A) || (mode_i == MD_RISE_B);
  assign lim      = (mode_i == MD_RISE_A) ? LIM_A : LIM_B;
  assign div_hit  = div_mode & rise_i & (pre_cnt == lim);

  always_comb begin
    cap_o     = 1'b0;
    pin_irq_o = 1'b0;
    if (!chg_o && !off_o) begin
      if (mode_i == MD_IRQ) begin
        pin_irq_o = rise_i;            // R5: works in every power state
      end else if (full_fn) begin
        unique case (icap_mode_e'(mode_i))
          MD_BOTH:   cap_o = rise_i | fall_i;
          MD_FALL:   cap_o = fall_i;
          MD_RISE:   cap_o = rise_i;
          MD_RISE_A,
          MD_RISE_B: cap_o = div_hit;
          default:   cap_o = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode <= 3'b000;
      pre_cnt   <= '0;
    end else begin
      prev_mode <= mode_i;
      if (chg_o || off_o)
        pre_cnt <= '0;                 // R3: restart on mode change
      else if (full_fn && div_mode && rise_i)
        pre_cnt <= div_hit ? '0 : pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         rd_valid_o,
  input  logic         rd_ready_i,
  output logic [W-1:0] rd_data_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, pop, wr;

  assign full       = (cnt == FULL_CNT);
  assign rd_valid_o = (cnt != '0);
  assign rd_data_o  = mem[rptr];
  assign pop        = rd_valid_o & rd_ready_i;
  assign wr         = push_i & ~full;  // R11: occupancy at cycle start decides

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr && !flush_i) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_o <= 1'b0;
    end else if (flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr)  wptr <= nxt(wptr);
      if (pop) rptr <= nxt(rptr);
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/icap_irq.sv
module icap_irq #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             pin_irq_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [SEL_W-1:0] ev_cnt;
  logic             hit, set;

  assign hit = cap_i & (ev_cnt == sel_i);
  assign set = hit | pin_irq_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt <= '0;
      flag_o <= 1'b0;
    end else begin
      if (restart_i || hit) ev_cnt <= '0;     // R4
      else if (cap_i)       ev_cnt <= ev_cnt + 1'b1;
      if (set)        flag_o <= 1'b1;          // R8: set beats clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_wake_top.sv
module icap_wake_top #(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic [TW-1:0] tmr_cnt_i,
  input  logic          tmr_en_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    evt_sel_i,
  input  logic          stop_idle_i,
  input  logic [1:0]    pwr_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [TW-1:0] rd_data_o,
  output logic          ovf_o,
  output logic          irq_flag_o,
  output logic          irq_req_o,
  output logic          wake_o
);
  logic rise, fall, cap, pin_irq, chg, off;

  icap_sync_edge #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  icap_event_gen u_evt (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .mode_i(mode_i), .pwr_i(pwr_i), .tmr_en_i(tmr_en_i),
    .stop_idle_i(stop_idle_i), .cap_o(cap), .pin_irq_o(pin_irq),
    .chg_o(chg), .off_o(off)
  );

  icap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(off), .push_i(cap),
    .data_i(tmr_cnt_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .ovf_o(ovf_o)
  );

  icap_irq #(.SEL_W(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .pin_irq_i(pin_irq),
    .restart_i(chg | off), .sel_i(evt_sel_i), .clr_i(flag_clr_i),
    .flag_o(irq_flag_o)
  );

  // R9
  assign irq_req_o = irq_flag_o & irq_en_i;
  assign wake_o    = irq_req_o & (pwr_i != 2'b00);
endmodule

// File: rtl/icap_wake_chk.sv
module icap_wake_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic [1:0]    pwr_i,
  input logic          irq_en_i,
  input logic          flag_clr_i,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [TW-1:0] rd_data_o,
  input logic          ovf_o,
  input logic          irq_flag_o,
  input logic          wake_o
);
  logic off_now;
  assign off_now = (mode_i == 3'b000) || (mode_i == 3'b110);

  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_flag_o && irq_en_i && pwr_i != 2'b00));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !off_now) |=> ovf_o);

  p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !off_now) |=> (rd_valid_o && $stable(rd_data_o)));

  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_i[1] && mode_i != 3'b111 && !irq_flag_o) |=> !irq_flag_o);

  p_off_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b000) |=> (!rd_valid_o && !ovf_o));
endmodule

bind icap_wake_top icap_wake_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pwr_i(pwr_i),
  .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .rd_valid_o(rd_valid_o),
  .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .ovf_o(ovf_o),
  .irq_flag_o(irq_flag_o), .wake_o(wake_o)
);

// File: tb/icap_wake_top_tb.sv
module icap_wake_top_tb;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_i = 1'b0;
  logic [TW-1:0] tmr_cnt_i = '0;
  logic          tmr_en_i = 1'b1;
  logic [2:0]    mode_i = 3'b000;
  logic [1:0]    evt_sel_i = 2'b00;
  logic          stop_idle_i = 1'b0;
  logic [1:0]    pwr_i = 2'b00;
  logic          irq_en_i = 1'b0;
  logic          flag_clr_i = 1'b0;
  logic          rd_ready_i = 1'b0;
  logic          rd_valid_o, ovf_o, irq_flag_o, irq_req_o, wake_o;
  logic [TW-1:0] rd_data_o;

  always #2 clk = ~clk;   // 250 MHz

  icap_wake_top #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tmr_cnt_i(tmr_cnt_i),
    .tmr_en_i(tmr_en_i), .mode_i(mode_i), .evt_sel_i(evt_sel_i),
    .stop_idle_i(stop_idle_i), .pwr_i(pwr_i), .irq_en_i(irq_en_i),
    .flag_clr_i(flag_clr_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .ovf_o(ovf_o), .irq_flag_o(irq_flag_o),
    .irq_req_o(irq_req_o), .wake_o(wake_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_d1, m_d2, m_d3, m_flag, m_ovf;
  int m_prev, m_pre, m_cnt;
  int m_q[$];

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) tmr_cnt_i <= tmr_cnt_i + 1'b1;

  always @(posedge clk) begin
    bit rise, fall, chg, off, ffn, cap, ev, wasfull;
    int md;
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 0; m_d3 = 0; m_flag = 0; m_ovf = 0;
      m_prev = 0; m_pre = 0; m_cnt = 0; m_q.delete();
    end else begin
      rise = m_d2 && !m_d3;
      fall = !m_d2 && m_d3;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = pin_i;
      md = int'(mode_i);
      chg = (md != m_prev);
      m_prev = md;
      off = (md == 0) || (md == 6);
      ffn = (pwr_i == 0) || (pwr_i == 1 && !stop_idle_i && tmr_en_i);
      cap = 0; ev = 0;
      if (chg || off) begin
        m_pre = 0; m_cnt = 0;
      end else if (md == 7) begin
        ev = rise;
      end else if (ffn) begin
        case (md)
          1: cap = rise || fall;
          2: cap = fall;
          3: cap = rise;
          4, 5: if (rise) begin
            if (m_pre == ((md == 4) ? 3 : 15)) begin cap = 1; m_pre = 0; end
            else m_pre++;
          end
          default: cap = 0;
        endcase
      end
      if (cap) begin
        if (m_cnt == int'(evt_sel_i)) begin ev = 1; m_cnt = 0; end
        else m_cnt = (m_cnt + 1) % 4;
      end
      wasfull = (m_q.size() == 4);
      if (off) begin
        m_q.delete(); m_ovf = 0;
      end else begin
        if (m_q.size() > 0 && rd_ready_i) void'(m_q.pop_front());
        if (cap) begin
          if (wasfull) m_ovf = 1;
          else m_q.push_back(int'(tmr_cnt_i));
        end
      end
      if (ev) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
    end
    #1;
    if (!done) begin
      chk("irq_flag_o", irq_flag_o, m_flag);
      chk("irq_req_o", irq_req_o, m_flag && irq_en_i);
      chk("wake_o", wake_o, m_flag && irq_en_i && pwr_i != 0);
      chk("rd_valid_o", rd_valid_o, m_q.size() > 0);
      chk("ovf_o", ovf_o, m_ovf);
      if (m_q.size() > 0) chk("rd_data_o", int'(rd_data_o), m_q[0]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_i = 1'b1; cyc(4);
      pin_i = 1'b0; cyc(4);
    end
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("reset flag", irq_flag_o, 0);
    chk("reset valid", rd_valid_o, 0);
    chk("reset wake", wake_o, 0);
    rst_n = 1'b1;
    cyc(2);

    cur_req = "R2";
    irq_en_i = 1'b1;
    mode_i = 3'b011; cyc(2);
    pulses(2);
    chk("R2 two rising captures queued", rd_valid_o, 1);
    clear_flag();
    mode_i = 3'b001; cyc(2); pulses(1);
    mode_i = 3'b010; cyc(2); pulses(1);

    cur_req = "R10";
    rd_ready_i = 1'b1; cyc(1); rd_ready_i = 1'b0; cyc(3);
    rd_ready_i = 1'b1; cyc(6); rd_ready_i = 1'b0;

    cur_req = "R11";
    mode_i = 3'b011; cyc(2); pulses(6);
    chk("R11 overflow after six captures", ovf_o, 1);
    rd_ready_i = 1'b1; pulses(1); rd_ready_i = 1'b0;

    cur_req = "R12";
    mode_i = 3'b110; cyc(2);
    chk("R12 queue flushed", rd_valid_o, 0);
    chk("R12 overflow cleared", ovf_o, 0);
    pulses(2);
    mode_i = 3'b000; cyc(2);

    cur_req = "R3";
    clear_flag();
    rd_ready_i = 1'b1;
    mode_i = 3'b100; cyc(2); pulses(9);
    mode_i = 3'b101; cyc(2); pulses(20);
    mode_i = 3'b100; cyc(2); pulses(3);

    cur_req = "R4";
    for (int s = 1; s < 4; s++) begin
      clear_flag();
      evt_sel_i = 2'(s);
      mode_i = 3'b011; cyc(2);
      pulses(s);
      chk("R4 flag still clear before last capture", irq_flag_o, 0);
      pulses(1);
      chk("R4 flag after selected count", irq_flag_o, 1);
      mode_i = 3'b000; cyc(2);
    end
    evt_sel_i = 2'b00;

    cur_req = "R8";
    mode_i = 3'b011; cyc(2);
    flag_clr_i = 1'b1; pulses(3); flag_clr_i = 1'b0;

    cur_req = "R6";
    pwr_i = 2'b10; mode_i = 3'b011; cyc(2); clear_flag();
    pulses(3);
    chk("R6 no flag in sleep", irq_flag_o, 0);
    mode_i = 3'b101; cyc(2); pulses(17);
    cur_req = "R5";
    tmr_en_i = 1'b0; mode_i = 3'b111; cyc(2);
    pulses(1);
    chk("R5 wake in sleep without timer", wake_o, 1);
    clear_flag();
    pwr_i = 2'b00; pulses(1); clear_flag();

    cur_req = "R7";
    mode_i = 3'b011; pwr_i = 2'b01; cyc(2); pulses(2);
    tmr_en_i = 1'b1; stop_idle_i = 1'b1; pulses(2);
    stop_idle_i = 1'b0; pulses(2);
    cur_req = "R9";
    irq_en_i = 1'b0; cyc(3); irq_en_i = 1'b1; cyc(3);
    pwr_i = 2'b00; cyc(3);

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) pin_i = ~pin_i;
      rd_ready_i = ($urandom_range(0, 3) == 0);
      flag_clr_i = ($urandom_range(0, 7) == 0);
      irq_en_i = $urandom_range(0, 1);
      if ($urandom_range(0, 150) == 0) mode_i = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 200) == 0) pwr_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 200) == 0) tmr_en_i = $urandom_range(0, 1);
      if ($urandom_range(0, 200) == 0) stop_idle_i = $urandom_range(0, 1);
      if ($urandom_range(0, 300) == 0) evt_sel_i = 2'($urandom_range(0, 3));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule